// File: doc/BRIEF.md
# Programmable Pulse Delay Channel

This block is a sampled-time model of a four-lane timing deskew element. It runs on a fast sample clock, and every lane carries one pulse line. Each lane takes its pulse either from one shared input (fanout) or from its own input (pass-through), which one depending on a single select line. The lane then shifts the stream later by a coarse amount plus an optional fine amount. Its falling edges can also be moved by a signed offset, which changes pulse width on purpose.

Edges are not carried through a per-tick delay line. Each lane turns an input edge into a due time when the edge arrives and places it in a small queue. The edge is emitted when the free-running tick counter reaches that time. Long delays therefore cost only a few queue entries.

Each lane has two sticky flags, cleared only by reset. One is set when a falling offset would make a pulse vanish, in which case the pulse is dropped. The other is set when the queue overflows.

Top module: `pulse_deskew_quad`

## Requirements
- R1: When `sel_fanout` is 1, every lane takes `common_in` and ignores its own `chan_in` bit.
- R2: When `sel_fanout` is 0, lane i takes `chan_in[i]` and ignores `common_in`.
- R3: A rising input edge reaches the lane output D+1 clock cycles later, where D = 64 + 32·coarse + (fine enabled ? fine : 0). The coarse code is 6 bits at `coarse_code[6i+:6]` and the fine code is 6 bits at `fine_code[6i+:6]`.
- R4: When `fine_en[i]` is 0, the fine code of lane i has no effect on either edge.
- R5: When `fall_en[i]` is 1, a falling edge uses the delay F = D + (code − 64), where the code is 7 bits at `fall_code[7i+:7]`. It appears max(F,1)+1 cycles after the input edge. Rising edges are unaffected.
- R6: When `fall_en[i]` is 0, falling edges use the same delay D as rising edges, so the output width equals the input width.
- R7: If a falling edge's due time is at or before the due time of its own still-pending rising edge, the lane emits neither edge and `err_short[i]` becomes 1 and stays 1.
- R8: Each lane holds at most 8 pending edges. An edge that arrives at a full queue is discarded and `err_ovf[i]` becomes 1 and stays 1.
- R9: The settings and inputs of one lane never change the output or flags of another lane.
- R10: A lane's settings are taken when an edge arrives. Changing them later has no effect on edges already queued.
- R11: Reset clears all outputs and flags, and no output goes high within 64 cycles after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_fanout | input | 1 | 1: all lanes take the shared input; 0: each lane takes its own |
| common_in | input | 1 | Shared pulse input |
| chan_in | input | NCH | Per-lane pulse inputs |
| coarse_code | input | NCH*6 | Coarse step code per lane |
| fine_en | input | NCH | Fine delay enable per lane |
| fine_code | input | NCH*6 | Fine tick code per lane |
| fall_en | input | NCH | Falling offset enable per lane |
| fall_code | input | NCH*7 | Falling offset code per lane, 64 = no offset |
| pulse_out | output | NCH | Delayed pulse lines |
| err_short | output | NCH | Sticky flag: pulse removed by its falling offset |
| err_ovf | output | NCH | Sticky flag: edge lost to a full queue |

## Verification
The bench keeps the default parameters: four lanes, 32-tick coarse step, 64-tick base, 8-entry queue. With these values the largest delay, about 2200 ticks, fits in a short run. Maximum coarse codes are therefore measured exactly, and ten closely spaced edges behind that delay fill the queue past its limit. The 64-tick base puts the zero-delay falling case and the exact "fall equals rise" boundary a few ticks apart, and both sides of that boundary are driven.

// File: rtl/pulse_deskew_quad.sv
module pulse_deskew_quad #(
  parameter int NCH   = 4,
  parameter int CW    = 6,
  parameter int FW    = 6,
  parameter int AW    = 7,
  parameter int STEP  = 32,
  parameter int BASE  = 64,
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_fanout,
  input  logic               common_in,
  input  logic [NCH-1:0]     chan_in,
  input  logic [NCH*CW-1:0]  coarse_code,
  input  logic [NCH-1:0]     fine_en,
  input  logic [NCH*FW-1:0]  fine_code,
  input  logic [NCH-1:0]     fall_en,
  input  logic [NCH*AW-1:0]  fall_code,
  output logic [NCH-1:0]     pulse_out,
  output logic [NCH-1:0]     err_short,
  output logic [NCH-1:0]     err_ovf
);
  localparam int OFS  = 1 << (AW - 1);
  localparam int MAXD = BASE + ((1 << CW) - 1) * STEP + (1 << FW) - 1 + (1 << AW) - 1 - OFS;
  localparam int TW   = $clog2(MAXD + 1) + 1;
  localparam int PW   = $clog2(DEPTH);
  localparam int NW   = $clog2(DEPTH + 1);

  logic [TW-1:0] now;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    logic          src, prev, rise, fall, short_hit, full, push, pop, due;
    logic          out_r, rise_q, s_err, o_err, head_lvl;
    logic [TW-1:0] d_rise, d_fall, ts_r, ts_f, last_r, head_ts, gap, lag;
    logic [TW:0]   q [DEPTH];
    logic [PW-1:0] rp, wp;
    logic [NW-1:0] cnt;

    assign src  = sel_fanout ? common_in : chan_in[g];
    assign rise = src & ~prev;
    assign fall = ~src & prev;

    assign d_rise = TW'(BASE) + TW'(coarse_code[g*CW +: CW]) * TW'(STEP)
                  + (fine_en[g] ? TW'(fine_code[g*FW +: FW]) : '0);
    assign d_fall = d_rise + (fall_en[g] ? TW'(fall_code[g*AW +: AW]) - TW'(OFS) : '0);
    assign ts_r   = now + d_rise;
    assign ts_f   = now + d_fall;

    assign gap       = last_r - ts_f;
    assign short_hit = fall & rise_q & ~gap[TW-1];
    assign full      = cnt == NW'(DEPTH);
    assign push      = (rise | (fall & ~short_hit)) & ~full;

    assign {head_lvl, head_ts} = q[rp];
    assign lag = now - head_ts;
    assign due = (cnt != '0) & ~lag[TW-1];
    assign pop = due & ~(short_hit & (cnt == NW'(1)));

    always_ff @(posedge clk)
      if (push) q[wp] <= {rise, rise ? ts_r : ts_f};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        prev   <= 1'b0;
        rp     <= '0;
        wp     <= '0;
        cnt    <= '0;
        rise_q <= 1'b0;
        last_r <= '0;
        out_r  <= 1'b0;
        s_err  <= 1'b0;
        o_err  <= 1'b0;
      end else begin
        prev <= src;
        if (push)           wp <= wp + 1'b1;
        else if (short_hit) wp <= wp - 1'b1;
        if (pop) begin
          rp    <= rp + 1'b1;
          out_r <= head_lvl;
        end
        cnt <= cnt + NW'(push) - NW'(pop) - NW'(short_hit);
        if (rise) begin
          last_r <= ts_r;
          rise_q <= ~full;
        end else if (fall || (pop && cnt == NW'(1))) begin
          rise_q <= 1'b0;
        end
        s_err <= s_err | short_hit;
        o_err <= o_err | ((rise | (fall & ~short_hit)) & full);
      end

    assign pulse_out[g] = out_r;
    assign err_short[g] = s_err;
    assign err_ovf[g]   = o_err;
  end
endmodule

// File: rtl/pulse_deskew_quad_chk.sv
module pulse_deskew_quad_chk #(
  parameter int NCH  = 4,
  parameter int BASE = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sel_fanout,
  input logic           common_in,
  input logic [NCH-1:0] chan_in,
  input logic [NCH-1:0] pulse_out,
  input logic [NCH-1:0] err_short,
  input logic [NCH-1:0] err_ovf
);
  localparam int SW = $clog2(BASE + 1);

  logic [NCH-1:0] src;
  logic [SW-1:0]  since;

  assign src = sel_fanout ? {NCH{common_in}} : chan_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 since <= '0;
    else if (since != SW'(BASE)) since <= since + 1'b1;

  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (since < SW'(BASE)) |-> (pulse_out == '0)); // R11

  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err_short) & ~err_short) == '0)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err_ovf) & ~err_ovf) == '0)); // R8

  for (genvar i = 0; i < NCH; i++) begin : g_lane_chk
    AST_SHORT_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_short[i]) |-> (!$past(src[i]) && $past(src[i], 2))); // R7

    AST_OVF_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_ovf[i]) |-> ($past(src[i]) != $past(src[i], 2))); // R8
  end
endmodule

bind pulse_deskew_quad pulse_deskew_quad_chk #(.NCH(NCH), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_fanout(sel_fanout), .common_in(common_in),
  .chan_in(chan_in), .pulse_out(pulse_out), .err_short(err_short), .err_ovf(err_ovf)
);

// File: tb/pulse_deskew_quad_test.sv
`timescale 1ns/1ps
module pulse_deskew_quad_test;
  logic       clk = 1'b0, rst_n = 1'b0, sel = 1'b0, com = 1'b0;
  logic [3:0] chin = '0, fen = '0, aen = '0;
  logic [5:0] cc [4];
  logic [5:0] fc [4];
  logic [6:0] ac [4];
  wire  [3:0] pout, eshort, eovf;

  pulse_deskew_quad uut (
    .clk(clk), .rst_n(rst_n), .sel_fanout(sel), .common_in(com), .chan_in(chin),
    .coarse_code({cc[3], cc[2], cc[1], cc[0]}), .fine_en(fen),
    .fine_code({fc[3], fc[2], fc[1], fc[0]}), .fall_en(aen),
    .fall_code({ac[3], ac[2], ac[1], ac[0]}),
    .pulse_out(pout), .err_short(eshort), .err_ovf(eovf)
  );

  always #5 clk = ~clk;

  int  rise_t [4];
  int  fall_t [4];
  int  nrise  [4];
  int  checks = 0, errs = 0;
  bit  done = 0;
  logic [3:0] smask = '0;

  // columns: lane, coarse, fine_en, fine, fall_en, fall_code, width
  localparam int VEC [9][7] = '{
    '{0,  0, 0,  0, 0,   0,  10},
    '{1,  3, 1, 17, 0,   0,  40},
    '{2,  1, 0, 50, 1, 100,  20},
    '{3, 63, 1, 63, 1, 127, 200},
    '{0,  2, 1,  5, 1,  30,  50},
    '{1,  0, 0,  0, 1,   0, 100},
    '{2,  0, 0,  0, 1,   0,  30},
    '{3,  0, 0,  0, 1,  10,  54},
    '{0,  0, 0,  0, 1,  10,  55}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int c = 0; c < 4; c++) begin
      cc[c] = '0; fc[c] = '0; ac[c] = '0;
    end
    fen = '0; aen = '0;
  endtask

  task automatic run(input bit use_com, input logic [3:0] mask, input int w,
                     input int win, input int chg_k, input int chg_coarse);
    logic [3:0] last;
    last = pout;
    for (int c = 0; c < 4; c++) begin
      rise_t[c] = -1; fall_t[c] = -1; nrise[c] = 0;
    end
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++)
        if (pout[c] !== last[c]) begin
          if (pout[c]) begin
            nrise[c]++;
            if (rise_t[c] < 0) rise_t[c] = k;
          end else if (fall_t[c] < 0) fall_t[c] = k;
        end
      last = pout;
      if (k == chg_k) cc[0] = 6'(chg_coarse);
      if (k == 0) begin
        if (use_com) com = 1'b1;
        chin = mask;
      end
      if (k == w) begin
        com = 1'b0; chin = '0;
      end
    end
  endtask

  function automatic int lat_r(input int c, input int fe, input int f);
    return 65 + 32 * c + (fe != 0 ? f : 0);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL R3 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    clear_cfg();
    repeat (4) @(negedge clk);
    chk("R11 reset pulse_out", int'(pout), 0);
    chk("R11 reset err_short", int'(eshort), 0);
    chk("R11 reset err_ovf", int'(eovf), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 9; v++) begin
      int ch, lr, df, lf, w, win;
      bit short_p;
      ch = VEC[v][0]; w = VEC[v][6];
      cc[ch] = 6'(VEC[v][1]); fen[ch] = VEC[v][2] != 0; fc[ch] = 6'(VEC[v][3]);
      aen[ch] = VEC[v][4] != 0; ac[ch] = 7'(VEC[v][5]);
      lr = lat_r(VEC[v][1], VEC[v][2], VEC[v][3]);
      df = lr - 1 + (VEC[v][4] != 0 ? VEC[v][5] - 64 : 0);
      short_p = (w + df) <= (lr - 1);
      lf = (df < 1 ? 1 : df) + 1;
      win = (lr > w + lf ? lr : w + lf) + 20;
      run(1'b0, 4'b0001 << ch, w, win, -1, 0);
      if (short_p) begin
        smask[ch] = 1'b1;
        chk("R7 dropped rise", rise_t[ch], -1);
        chk("R7 dropped fall", fall_t[ch], -1);
      end else begin
        chk((VEC[v][2] == 0 && VEC[v][3] != 0) ? "R4 rise latency, fine ignored" : "R3 rise latency",
            rise_t[ch], lr);
        chk(VEC[v][4] != 0 ? "R5 fall latency" : "R6 fall latency", fall_t[ch], w + lf);
      end
      for (int o = 0; o < 4; o++)
        if (o != ch) chk("R9 idle lane quiet", rise_t[o], -1);
      chk("R7 err_short mask", int'(eshort), int'(smask));
    end

    clear_cfg();
    cc[1] = 6'd1; cc[2] = 6'd2; fen[2] = 1'b1; fc[2] = 6'd7; aen[3] = 1'b1; ac[3] = 7'd80;
    @(negedge clk); sel = 1'b1;
    run(1'b1, 4'b0000, 30, 220, -1, 0);
    chk("R1 fanout rise lane0", rise_t[0], 65);
    chk("R1 fanout rise lane1", rise_t[1], 97);
    chk("R1 fanout rise lane2", rise_t[2], 136);
    chk("R1 fanout rise lane3", rise_t[3], 65);
    chk("R9 fanout fall lane2", fall_t[2], 166);
    chk("R5 fanout fall lane3", fall_t[3], 111);
    run(1'b0, 4'b1111, 30, 220, -1, 0);
    for (int c = 0; c < 4; c++) chk("R1 own input ignored in fanout", rise_t[c], -1);
    @(negedge clk); sel = 1'b0;
    run(1'b1, 4'b0000, 30, 220, -1, 0);
    for (int c = 0; c < 4; c++) chk("R2 common ignored in pass-through", rise_t[c], -1);
    run(1'b0, 4'b0110, 30, 220, -1, 0);
    chk("R2 pass-through lane1", rise_t[1], 97);
    chk("R2 pass-through lane2", rise_t[2], 136);
    chk("R9 undriven lane0", rise_t[0], -1);
    chk("R9 undriven lane3", rise_t[3], -1);

    clear_cfg();
    run(1'b0, 4'b0001, 20, 200, 5, 2);
    chk("R10 queued rise keeps old setting", rise_t[0], 65);
    chk("R10 later fall uses new setting", fall_t[0], 149);

    clear_cfg();
    cc[0] = 6'd63;
    chk("R8 no overflow yet", int'(eovf), 0);
    for (int c = 0; c < 4; c++) nrise[c] = 0;
    rise_t[0] = -1;
    begin
      logic last0;
      last0 = pout[0];
      for (int k = 0; k < 2400; k++) begin
        @(negedge clk);
        if (pout[0] !== last0 && pout[0]) begin
          nrise[0]++;
          if (rise_t[0] < 0) rise_t[0] = k;
        end
        last0 = pout[0];
        chin[0] = (k < 20) && ((k / 2) % 2 == 0);
      end
    end
    chk("R3 maximum coarse latency", rise_t[0], 2017 + 64);
    chk("R8 pulses kept", nrise[0], 4);
    chk("R8 err_ovf", int'(eovf), 1);
    chk("R8 output low at end", int'(pout[0]), 0);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R11 flags cleared by reset", int'({eshort, eovf}), 0);
    chk("R11 outputs cleared by reset", int'(pout), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule